// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational unsigned adder. It takes two N-bit operands and a carry input, and it returns an N-bit sum and a carry output. The operand bits are divided into consecutive blocks. The blocks get wider from the least significant end toward the most significant end.

The lowest block is a plain ripple stage fed by the external carry input. Every higher block computes two candidate results ahead of time: one for an incoming carry of 0 and one for an incoming carry of 1. The true carry arriving from the block below then picks one of the two candidates through a multiplexer. Because the block widths grow, the ripple time inside a block overlaps with the mux chain, and the worst-case delay scales with the square root of N.

The width and the block partition are parameters. The default is 16 bits split into blocks of 2, 2, 3, 4 and 5 bits, starting from the LSB. Elaboration rejects a partition whose widths do not add up to N or that shrinks toward the MSB.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, where the addition is unsigned.
- R2: `cout_o` equals bit WIDTH of the same (WIDTH+1)-bit unsigned total.
- R3: When every bit position propagates (`a_i ^ b_i` all ones and `a_i & b_i` zero):
  - with `cin_i = 1`, `sum_o` is all zeros and `cout_o` is 1;
  - with `cin_i = 0`, `sum_o` is all ones and `cout_o` is 0.
- R4: The default partition is 16 bits in blocks of 2, 2, 3, 4 and 5 from the LSB upward. Elaboration fails if the block widths do not add up to WIDTH, or if any block is narrower than the block below it.
- R5: A carry generated in the top bit of any block is passed through every higher block that propagates. With `a_i` all ones and a single set bit k in `b_i`, `sum_o` has bits k and above cleared, and `cout_o` is 1.
- R6: With both operands zero, `sum_o` equals `cin_i` placed in bit 0, and `cout_o` is 0.
- R7: The outputs follow the inputs within the same cycle. There is no register between operands and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The bound checker compares sum and carry against a behavioural addition whenever the inputs change. It also checks the all-propagate case and the zero-operand case directly. Those checks cover R1, R2, R3 and R6 for every applied vector.

Some behaviour is shown only by the bench's chosen vectors. These are the carry launched at each block boundary (R5), the same-cycle response (R7), and the default partition being accepted (R4).

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_NBLK  = 5;
  localparam int unsigned DEF_BLK_W [DEF_NBLK] = '{2, 2, 3, 4, 5};
endpackage

// File: rtl/csel_ripple_blk.sv
module csel_ripple_blk #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   carry;
  logic [W-1:0] gen;
  logic [W-1:0] prop;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]      = a_i[i] & b_i[i];
    assign prop[i]     = a_i[i] ^ b_i[i];
    assign carry[i+1]  = gen[i] | (prop[i] & carry[i]);
    assign sum_o[i]    = prop[i] ^ carry[i];
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/csel_select_blk.sv
module csel_select_blk #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] sum_c0, sum_c1;
  logic         co_c0, co_c1;

  csel_ripple_blk #(.W(W)) u_cand0 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(sum_c0), .cout_o(co_c0)
  );

  csel_ripple_blk #(.W(W)) u_cand1 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(sum_c1), .cout_o(co_c1)
  );

  always_comb begin
    if (cin_i) begin
      sum_o  = sum_c1;
      cout_o = co_c1;
    end else begin
      sum_o  = sum_c0;
      cout_o = co_c0;
    end
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqrt_csel_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned NBLK  = DEF_NBLK,
  parameter int unsigned BLK_W [NBLK] = DEF_BLK_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  function automatic int unsigned blk_lsb(int unsigned k);
    int unsigned s = 0;
    for (int unsigned j = 0; j < k; j++) s += BLK_W[j];
    return s;
  endfunction

  localparam int unsigned TOTAL_W = blk_lsb(NBLK);

  // R4: partition must cover the word exactly and never narrow toward the MSB
  if (TOTAL_W != WIDTH) begin : g_bad_total
    $error("block widths do not add up to WIDTH");
  end
  for (genvar k = 1; k < NBLK; k++) begin : g_mono
    if (BLK_W[k] < BLK_W[k-1]) begin : g_bad_order
      $error("block widths must not shrink toward the MSB");
    end
  end

  logic [NBLK:0] blk_carry;
  assign blk_carry[0] = cin_i;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int unsigned LSB = blk_lsb(k);
    localparam int unsigned BW  = BLK_W[k];
    if (k == 0) begin : g_base
      csel_ripple_blk #(.W(BW)) u_blk (
        .a_i   (a_i[LSB +: BW]),
        .b_i   (b_i[LSB +: BW]),
        .cin_i (blk_carry[k]),
        .sum_o (sum_o[LSB +: BW]),
        .cout_o(blk_carry[k+1])
      );
    end else begin : g_sel
      csel_select_blk #(.W(BW)) u_blk (
        .a_i   (a_i[LSB +: BW]),
        .b_i   (b_i[LSB +: BW]),
        .cin_i (blk_carry[k]),
        .sum_o (sum_o[LSB +: BW]),
        .cout_o(blk_carry[k+1])
      );
    end
  end

  assign cout_o = blk_carry[NBLK];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] ref_total;

  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    p_sum_r1: assert (sum_o == ref_total[WIDTH-1:0])
      else $error("sum mismatch");

    p_cout_r2: assert (cout_o == ref_total[WIDTH])
      else $error("carry-out mismatch");

    if (((a_i ^ b_i) == '1) && ((a_i & b_i) == '0)) begin
      p_allprop_r3: assert ((sum_o == {WIDTH{~cin_i}}) && (cout_o == cin_i))
        else $error("all-propagate case wrong");
    end

    if ((a_i == '0) && (b_i == '0)) begin
      p_zero_ops_r6: assert ((sum_o == {{(WIDTH-1){1'b0}}, cin_i}) && !cout_o)
        else $error("zero-operand case wrong");
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] sum;
    logic         cout;
    string        req;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b, s;
  logic         ci, co;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  exp_t sb_q[$];

  sqrt_csel_adder u_sqrt_csel_adder (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: apply one vector per cycle, push expected result
  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string req);
    logic [W:0] t;
    exp_t e;
    @(posedge clk);
    #1;
    a = va; b = vb; ci = vc;
    t = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    e.sum = t[W-1:0];
    e.cout = t[W];
    e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: outputs must already hold the result in the same cycle (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (s !== e.sum || co !== e.cout) begin
          n_fail++;
          $display("FAIL %s: got sum=%h cout=%b expected sum=%h cout=%b",
                   e.req, s, co, e.sum, e.cout);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bnd[5];
    a = '0; b = '0; ci = 1'b0;
    rst_n = 1'b0;
    drive(16'h0000, 16'h0000, 1'b0, "R1 reset state");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    drive(16'h0000, 16'h0000, 1'b1, "R6 zero operands cin=1");
    drive(16'h0000, 16'h0000, 1'b0, "R6 zero operands cin=0");
    drive(16'hFFFF, 16'h0000, 1'b1, "R3 all propagate cin=1");
    drive(16'hAAAA, 16'h5555, 1'b1, "R3 alternating propagate cin=1");
    drive(16'h0F0F, 16'hF0F0, 1'b0, "R3 all propagate cin=0");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 maximum total");
    drive(16'h8000, 16'h8000, 1'b0, "R2 msb generate only");

    // R5: block tops of the default partition 2,2,3,4,5 (R4)
    bnd = '{1, 3, 6, 10, 15};
    foreach (bnd[i]) drive(16'hFFFF, 16'h0001 << bnd[i], 1'b0, "R5 generate at block top");
    for (int k = 0; k < W; k++) drive(16'hFFFF, 16'h0001 << k, 1'b0, "R5 generate per bit");

    // R4: default partition boundary carries (bits 2,4,7,11 receive carries)
    drive(16'h0003, 16'h0001, 1'b0, "R4 carry into block 1");
    drive(16'h000F, 16'h0001, 1'b0, "R4 carry into block 2");
    drive(16'h007F, 16'h0000, 1'b1, "R4 carry into block 3");
    drive(16'h07FF, 16'h0000, 1'b1, "R4 carry into block 4");

    for (int i = 0; i < 400; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random vector");

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule